// File: doc/BRIEF.md
# Run-of-three ones detector

This block watches a single serial data bit, sampled on each rising clock edge, and reports when three ones in a row have been seen. Two detector machines run side by side from the same clock, reset and data bit. Each keeps its own state.

The first machine is state-based. Its flag comes straight from a state register. It therefore rises in the cycle after the third one has been sampled, and it is steady for that whole cycle. The second machine is transition-based. Its flag is the present data bit gated by its state. It rises during the cycle in which the third one is presented, which is one cycle ahead of the registered flag.

Runs may overlap. While the ones continue, both flags stay high. The smaller machine has a spare state code. That code leads back to idle on the next clock, so the machine recovers without a reset.

Top module: `run3_detect`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, both flags are 0, whatever bit_i does. Reset puts both machines in their idle code 2'b00, and a reset in the middle of a run discards that run.
- R2: When bit_i is 0 at a rising edge, run_reg_o is 0 in the following cycle.
- R3: run_reg_o is 1 in the cycle after the third consecutive 1 has been sampled. It stays 1 in every later cycle for as long as the sampled bits are 1.
- R4: run_reg_o does not depend on the present value of bit_i. It is constant within a cycle.
- R5: run_comb_o equals bit_i AND (the two previously sampled bits were both 1). It rises in the same cycle as the third 1 is presented, one cycle before run_reg_o.
- R6: For a run longer than three ones, run_comb_o stays 1 for every bit of the run from the third bit on.
- R7: After reset, the input stream 0,1,0,1,1,0,1,1,1,1 gives run_comb_o = 0 for the first eight bits and 1 for the last two.
- R8: The transition-based machine encodes idle as 2'b00, one seen as 2'b01 and two or more seen as 2'b10. Its unused code 2'b11 gives run_comb_o = 0 and moves to 2'b00 on the next clock, whatever bit_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; rising edge samples bit_i |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit, synchronous to clk_i |
| run_reg_o | output | 1 | Registered flag (state-based machine) |
| run_comb_o | output | 1 | Early flag (transition-based machine) |

## Verification
The hardest situation to reach is the spare code 2'b11 of the transition-based machine, because no input sequence leads to it. The bench forces that state register to 2'b11 for one cycle with bit_i held at 1, and checks that the early flag stays low. It then confirms that the machine needs a fresh run of three ones from idle before the flag fires again. The other delicate point is the one-cycle lead of the early flag over the registered flag. To cover it, the bench changes bit_i in the middle of a cycle. It then checks that the registered flag holds still while the early flag follows the bit.

// File: rtl/run3_pkg.sv
package run3_pkg;
  localparam int unsigned ST_W = 2;
  localparam int unsigned RUN_LEN = 3;

  typedef logic [ST_W-1:0] st_t;

  // shared codes: count of consecutive ones seen
  localparam st_t ST_IDLE = 2'b00;
  localparam st_t ST_ONE  = 2'b01;
  localparam st_t ST_TWO  = 2'b10;
  localparam st_t ST_HIT  = 2'b11;
endpackage

// File: rtl/run3_level_fsm.sv
module run3_level_fsm
  import run3_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic hit_o
);
  st_t state_q, state_d;

  always_comb begin
    if (!bit_i)                state_d = ST_IDLE;
    else if (state_q == ST_HIT) state_d = ST_HIT;
    else                       state_d = state_q + st_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign hit_o = (state_q == ST_HIT);
endmodule

// File: rtl/run3_edge_fsm.sv
module run3_edge_fsm
  import run3_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bit_i,
  output logic      hit_o,
  output logic [1:0] state_o
);
  logic [1:0] state_q, state_d;

  always_comb begin
    unique case (state_q)
      ST_IDLE: state_d = bit_i ? ST_ONE : ST_IDLE;
      ST_ONE:  state_d = bit_i ? ST_TWO : ST_IDLE;
      ST_TWO:  state_d = bit_i ? ST_TWO : ST_IDLE;
      default: state_d = ST_IDLE; // spare code recovers without reset
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign hit_o   = bit_i && (state_q == ST_TWO);
  assign state_o = state_q;
endmodule

// File: rtl/run3_detect.sv
module run3_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic run_reg_o,
  output logic run_comb_o
);
  logic [1:0] edge_state;

  run3_level_fsm u_level (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (bit_i),
    .hit_o  (run_reg_o)
  );

  run3_edge_fsm u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (bit_i),
    .hit_o   (run_comb_o),
    .state_o (edge_state)
  );
endmodule

// File: rtl/run3_detect_chk.sv
module run3_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_i,
  input logic       run_reg_o,
  input logic       run_comb_o,
  input logic [1:0] edge_state
);
  assert_zero_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_i |=> !run_reg_o);

  assert_reg_lags_comb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_comb_o |=> run_reg_o);

  assert_run_continues_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_reg_o && bit_i) |-> run_comb_o);

  assert_comb_needs_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_comb_o |-> bit_i);

  assert_spare_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_state == 2'b11) |-> !run_comb_o);

  assert_spare_recovers_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_state == 2'b11) |=> (edge_state == 2'b00));
endmodule

bind run3_detect run3_detect_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_i      (bit_i),
  .run_reg_o  (run_reg_o),
  .run_comb_o (run_comb_o),
  .edge_state (edge_state)
);

// File: tb/run3_detect_tb_top.sv
`timescale 1ns/1ps
module run3_detect_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i = 1'b0;
  logic run_reg_o, run_comb_o;

  int checks = 0;
  int errors = 0;
  int ones = 0; // model: consecutive ones sampled, saturating at 3
  int cycles = 0;

  always #10 clk_i = ~clk_i; // 50 MHz

  run3_detect dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (bit_i),
    .run_reg_o  (run_reg_o),
    .run_comb_o (run_comb_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // drive one bit at negedge, check both flags just before the sampling edge
  task automatic apply(input logic b, input string req);
    @(negedge clk_i);
    bit_i = b;
    #5;
    chk({req, " reg"}, run_reg_o, ones >= 3);
    chk({req, " comb"}, run_comb_o, b && ones >= 2);
    @(posedge clk_i);
    ones = b ? ((ones < 3) ? ones + 1 : 3) : 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    bit_i = 1'b1;
    repeat (3) begin
      @(negedge clk_i);
      chk("R1 reg in reset", run_reg_o, 1'b0);
      chk("R1 comb in reset", run_comb_o, 1'b0);
    end
    rst_ni = 1'b1;
    bit_i = 1'b0;
    ones = 0;
    #5;
    chk("R1 reg after reset", run_reg_o, 1'b0);
    chk("R1 comb after reset", run_comb_o, 1'b0);
    @(posedge clk_i);
  endtask

  task automatic t_given_stream();
    logic [9:0] s = 10'b0101101111; // first bit in MSB
    for (int i = 9; i >= 0; i--) begin
      @(negedge clk_i);
      bit_i = s[i];
      #5;
      chk("R7 stream comb", run_comb_o, i < 2);
      @(posedge clk_i);
      ones = s[i] ? ((ones < 3) ? ones + 1 : 3) : 0;
    end
  endtask

  task automatic t_long_run();
    apply(1'b0, "R2");
    for (int i = 0; i < 7; i++) apply(1'b1, "R3 R6 long run");
    apply(1'b0, "R2 break");
    apply(1'b0, "R2 after break");
    apply(1'b1, "R3");
    apply(1'b1, "R3");
    apply(1'b0, "R2 two ones");
    apply(1'b1, "R5");
  endtask

  task automatic t_bit_toggle();
    apply(1'b0, "R2");
    for (int i = 0; i < 3; i++) apply(1'b1, "R3");
    @(negedge clk_i);
    bit_i = 1'b0;
    #2;
    chk("R4 reg bit0", run_reg_o, 1'b1);
    chk("R5 comb bit0", run_comb_o, 1'b0);
    bit_i = 1'b1;
    #2;
    chk("R4 reg bit1", run_reg_o, 1'b1);
    chk("R5 comb bit1", run_comb_o, 1'b1);
    @(posedge clk_i);
    apply(1'b0, "R2");
  endtask

  task automatic t_mid_reset();
    apply(1'b1, "R1 pre");
    apply(1'b1, "R1 pre");
    do_reset();
    apply(1'b1, "R1 run dropped");
    apply(1'b1, "R1 run dropped");
    apply(1'b1, "R1 fresh run");
    apply(1'b0, "R2");
  endtask

  task automatic t_spare_code();
    apply(1'b0, "R8 prep");
    @(negedge clk_i);
    bit_i = 1'b1;
    force dut_i.u_edge.state_q = 2'b11;
    #1 release dut_i.u_edge.state_q;
    #3;
    chk("R8 comb in spare", run_comb_o, 1'b0);
    @(posedge clk_i); // edge 00, level 01
    @(negedge clk_i); #5;
    chk("R8 comb after recover", run_comb_o, 1'b0);
    chk("R8 reg", run_reg_o, 1'b0);
    @(posedge clk_i); // edge 01, level 10
    @(negedge clk_i); #5;
    chk("R8 comb second", run_comb_o, 1'b0);
    chk("R8 reg second", run_reg_o, 1'b0);
    @(posedge clk_i); // edge 10, level 11
    @(negedge clk_i); #5;
    chk("R8 comb fires", run_comb_o, 1'b1);
    chk("R8 reg fires", run_reg_o, 1'b1);
    @(posedge clk_i);
    ones = 3;
    apply(1'b0, "R2");
  endtask

  initial begin
    do_reset();
    t_given_stream();
    do_reset();
    t_long_run();
    t_bit_toggle();
    t_mid_reset();
    t_spare_code();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule